// File: doc/BRIEF.md
# SPI Host Controller with Gated Interrupts

This block is a register-mapped SPI host. Software writes a byte into the transmit register. The block moves the byte into a one-word shifter and clocks it out MSB first in SPI mode 0. At the same time it shifts in the byte returned on the input line and holds it in the receive register. Status flags report the following conditions:

- transmit holding register empty
- receive data waiting
- receive overrun
- transmit overrun
- a combined error
- end of burst

Each flag has an enable bit in the control register. These bits sit at the same positions as the status flags they enable. One interrupt line rises whenever a flag and its enable are both set. A separate enable raises the interrupt on any error.

A select register chooses which active-low device selects the block drives. Normally the chosen selects go low only while a word is being shifted. They stay low for half a serial clock period after the last bit. A hold bit in the control register keeps them low while the shifter is idle, so several bytes can be framed as one longer transfer.

Register map (word addresses): 0 receive data (read), 1 transmit data (write), 2 status (read; a write of any value clears the sticky flags), 3 control, 4 device select.

Top module: `spi_host_irq`

## Requirements
- R1: After reset, the control and select registers read 0. Status reads 0x0040, meaning only transmitter-ready is set. All ss_n_o lines are high, irq_o is 0 and sclk_o is 0.
- R2: Control keeps only bits 3, 4, 6, 7, 8, 9 and 10 of a write. The select register keeps NUM_SS bits. Reading either register changes nothing in it.
- R3: A word is 8 bits, shifted MSB first in mode 0. sclk_o idles low and mosi_o is valid on each rising edge. miso_i is sampled on the rising edge. The sclk_o period is CLK_DIV clock cycles. The received byte is read at address 0, and status bit 7 (receiver ready) is set when the word ends.
- R4: With control bit 10 clear, the selected ss_n_o lines are low only from the start of a word's shift until half an sclk_o period (CLK_DIV/2 cycles) after its last falling edge. Lines that are not selected stay high at all times.
- R5: With control bit 10 set, the selected ss_n_o lines are low while the shifter is idle and stay low after a word ends.
- R6: Status bit 6 (transmitter ready) is 0 from a transmit write until that word is loaded into the shifter. A transmit write while bit 6 is 0 is ignored and sets status bit 4 (transmit overrun).
- R7: If a word ends while receiver ready is set, status bit 3 (receive overrun) is set and the receive register keeps its old byte. Reading address 0 clears receiver ready.
- R8: Status bit 5 is the OR of bits 3 and 4. Writing the status register clears bits 3, 4 and 9.
- R9: Status bit 9 (end of packet) is set when a word ends and no further transmit word is waiting.
- R10: irq_o is 1 exactly when a status bit among 3, 4, 6, 7 and 9 is set together with the same control bit, or when control bit 8 and status bit 5 are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 3 | Register word address |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational from addr_i |
| irq_o | output | 1 | Interrupt request |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_n_o | output | NUM_SS | Active-low device selects |

## Verification
The bench builds the block with CLK_DIV = 4 and NUM_SS = 3. A whole byte then takes only a few dozen cycles, so many transfers fit in each scenario, including overruns that need two words in a row. The smallest half-period of two cycles still lets the bench measure the serial clock period and the trailing select time as exact multiples of the clock. With three select lines the bench can choose one line and watch that the other two never go low.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  localparam int REG_AW = 3;
  localparam int REG_DW = 16;

  localparam logic [REG_AW-1:0] A_RX   = 3'd0;
  localparam logic [REG_AW-1:0] A_TX   = 3'd1;
  localparam logic [REG_AW-1:0] A_STAT = 3'd2;
  localparam logic [REG_AW-1:0] A_CTRL = 3'd3;
  localparam logic [REG_AW-1:0] A_SEL  = 3'd4;

  // status bits and their enables share positions
  localparam int B_ROE  = 3;
  localparam int B_TOE  = 4;
  localparam int B_ERR  = 5;
  localparam int B_TRDY = 6;
  localparam int B_RRDY = 7;
  localparam int B_IERR = 8;
  localparam int B_EOP  = 9;
  localparam int B_HOLD = 10;

  localparam logic [REG_DW-1:0] CTRL_MASK = 16'h07D8;
  localparam logic [REG_DW-1:0] PAIR_MASK = 16'h02D8;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_TAIL} shift_st_e;
endpackage

// File: rtl/spi_host_shifter.sv
module spi_host_shifter
  import spi_host_pkg::*;
#(
  parameter int CLK_DIV = 8,
  parameter int WORD_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_valid_i,
  input  logic [WORD_W-1:0] tx_word_i,
  input  logic              miso_i,
  output logic              load_o,
  output logic              done_o,
  output logic              busy_o,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              sclk_o,
  output logic              mosi_o
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BW   = (WORD_W > 1) ? $clog2(WORD_W) : 1;

  shift_st_e         st_q;
  logic [CW-1:0]     cnt_q;
  logic [BW-1:0]     bit_q;
  logic              phase_q;
  logic [WORD_W-1:0] tx_sr_q, rx_sr_q;
  logic              tick;

  assign tick      = (cnt_q == CW'(HALF - 1));
  assign load_o    = (st_q == ST_IDLE) && tx_valid_i;
  assign done_o    = (st_q == ST_TAIL) && tick;
  assign busy_o    = (st_q != ST_IDLE);
  assign sclk_o    = (st_q == ST_SHIFT) && phase_q;
  assign mosi_o    = tx_sr_q[WORD_W-1];
  assign rx_word_o = rx_sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      phase_q <= 1'b0;
      tx_sr_q <= '0;
      rx_sr_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (load_o) begin
            st_q    <= ST_SHIFT;
            tx_sr_q <= tx_word_i;
            cnt_q   <= '0;
            bit_q   <= '0;
            phase_q <= 1'b0;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            cnt_q <= '0;
            if (!phase_q) begin
              // rising edge: sample
              phase_q <= 1'b1;
              rx_sr_q <= {rx_sr_q[WORD_W-2:0], miso_i};
            end else begin
              // falling edge: advance
              phase_q <= 1'b0;
              if (bit_q == BW'(WORD_W - 1)) begin
                st_q <= ST_TAIL;
              end else begin
                bit_q   <= bit_q + 1'b1;
                tx_sr_q <= {tx_sr_q[WORD_W-2:0], 1'b0};
              end
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_TAIL: begin
          if (tick) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_LOAD_STARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> busy_o && !sclk_o); // R3
  AST_DONE_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o); // R4
endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs
  import spi_host_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int NUM_SS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [REG_DW-1:0] wdata_i,
  output logic [REG_DW-1:0] rdata_o,
  output logic              irq_o,
  input  logic              load_i,
  input  logic              done_i,
  input  logic [WORD_W-1:0] rx_word_i,
  output logic              tx_valid_o,
  output logic [WORD_W-1:0] tx_word_o,
  output logic              hold_o,
  output logic [NUM_SS-1:0] sel_o
);
  logic [REG_DW-1:0] ctrl_q, stat;
  logic [NUM_SS-1:0] sel_q;
  logic [WORD_W-1:0] tx_q, rx_q;
  logic              tx_full_q, rrdy_q, roe_q, toe_q, eop_q;
  logic              wr_tx, wr_stat, wr_ctrl, wr_sel, rd_rx;

  assign wr_tx   = wr_i && (addr_i == A_TX);
  assign wr_stat = wr_i && (addr_i == A_STAT);
  assign wr_ctrl = wr_i && (addr_i == A_CTRL);
  assign wr_sel  = wr_i && (addr_i == A_SEL);
  assign rd_rx   = rd_i && (addr_i == A_RX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      sel_q     <= '0;
      tx_q      <= '0;
      tx_full_q <= 1'b0;
      rx_q      <= '0;
      rrdy_q    <= 1'b0;
      roe_q     <= 1'b0;
      toe_q     <= 1'b0;
      eop_q     <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata_i & CTRL_MASK;
      if (wr_sel)  sel_q  <= wdata_i[NUM_SS-1:0];

      if (load_i) tx_full_q <= 1'b0;
      else if (wr_tx && !tx_full_q) begin
        tx_q      <= wdata_i[WORD_W-1:0];
        tx_full_q <= 1'b1;
      end

      if (wr_tx && tx_full_q) toe_q <= 1'b1;
      else if (wr_stat)       toe_q <= 1'b0;

      if (done_i && rrdy_q) roe_q <= 1'b1;
      else if (wr_stat)     roe_q <= 1'b0;

      if (done_i && !rrdy_q) begin
        rx_q   <= rx_word_i;
        rrdy_q <= 1'b1;
      end else if (rd_rx) begin
        rrdy_q <= 1'b0;
      end

      if (done_i && !tx_full_q) eop_q <= 1'b1;
      else if (wr_stat)         eop_q <= 1'b0;
    end
  end

  always_comb begin
    stat         = '0;
    stat[B_ROE]  = roe_q;
    stat[B_TOE]  = toe_q;
    stat[B_ERR]  = roe_q | toe_q;
    stat[B_TRDY] = ~tx_full_q;
    stat[B_RRDY] = rrdy_q;
    stat[B_EOP]  = eop_q;
  end

  assign irq_o = (|(stat & ctrl_q & PAIR_MASK)) | (ctrl_q[B_IERR] & stat[B_ERR]);

  always_comb begin
    case (addr_i)
      A_RX:    rdata_o = REG_DW'(rx_q);
      A_STAT:  rdata_o = stat;
      A_CTRL:  rdata_o = ctrl_q;
      A_SEL:   rdata_o = REG_DW'(sel_q);
      default: rdata_o = '0;
    endcase
  end

  assign tx_valid_o = tx_full_q;
  assign tx_word_o  = tx_q;
  assign hold_o     = ctrl_q[B_HOLD];
  assign sel_o      = sel_q;

  AST_TOE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_tx && tx_full_q && !load_i) |=> toe_q && $stable(tx_q)); // R6
  AST_ROE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && rrdy_q) |=> roe_q); // R7
  AST_RX_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && rrdy_q) |=> $stable(rx_q)); // R7
  AST_STAT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && !done_i && !wr_tx) |=> !roe_q && !toe_q && !eop_q); // R8
  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q == '0) |-> !irq_o); // R10
endmodule

// File: rtl/spi_host_irq.sv
module spi_host_irq
  import spi_host_pkg::*;
#(
  parameter int CLK_DIV = 8,
  parameter int NUM_SS  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rdata_o,
  output logic              irq_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NUM_SS-1:0] ss_n_o
);
  localparam int WORD_W = 8;

  logic              load, done, busy, tx_valid, hold;
  logic [WORD_W-1:0] tx_word, rx_word;
  logic [NUM_SS-1:0] sel;

  spi_host_regs #(.WORD_W(WORD_W), .NUM_SS(NUM_SS)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wr_i, .rd_i, .wdata_i, .rdata_o, .irq_o,
    .load_i(load), .done_i(done), .rx_word_i(rx_word),
    .tx_valid_o(tx_valid), .tx_word_o(tx_word), .hold_o(hold), .sel_o(sel)
  );

  spi_host_shifter #(.CLK_DIV(CLK_DIV), .WORD_W(WORD_W)) u_shift (
    .clk_i, .rst_ni, .tx_valid_i(tx_valid), .tx_word_i(tx_word), .miso_i,
    .load_o(load), .done_o(done), .busy_o(busy), .rx_word_o(rx_word),
    .sclk_o, .mosi_o
  );

  assign ss_n_o = ~(sel & {NUM_SS{busy | hold}});

  AST_SS_WHILE_CLOCKING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> (ss_n_o == ~sel)); // R4
  AST_SS_UNSELECTED_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    &(ss_n_o | sel)); // R4
  AST_SS_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !hold) |-> &ss_n_o); // R5
endmodule

// File: tb/spi_host_irq_tb.sv
`timescale 1ns/1ps
module spi_host_irq_tb;
  localparam int CLK_DIV = 4;
  localparam int NUM_SS  = 3;
  localparam realtime TCLK = 8.0;

  logic              clk = 1'b0, rst_n = 1'b0;
  logic [2:0]        addr = '0;
  logic              wr = 1'b0, rd = 1'b0;
  logic [15:0]       wdata = '0, rdata;
  logic              irq, sclk, mosi, miso;
  logic [NUM_SS-1:0] ss_n;

  int checks = 0, errors = 0;
  logic [7:0] dev_tx = '0, dev_rx = '0;
  int rises = 0;
  realtime t_rise0, t_rise1, t_last_fall, t_ss_rise;
  logic [NUM_SS-1:0] cur_sel = '0;
  logic unsel_bad = 1'b0;

  always #(TCLK/2) clk = ~clk;

  spi_host_irq #(.CLK_DIV(CLK_DIV), .NUM_SS(NUM_SS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .sclk_o(sclk),
    .mosi_o(mosi), .miso_i(miso), .ss_n_o(ss_n)
  );

  // device model, mode 0
  assign miso = dev_tx[7];
  always @(posedge sclk) begin
    dev_rx <= {dev_rx[6:0], mosi};
    if (rises == 0) t_rise0 = $realtime;
    if (rises == 1) t_rise1 = $realtime;
    rises++;
  end
  always @(negedge sclk) begin
    dev_tx <= {dev_tx[6:0], 1'b0};
    t_last_fall = $realtime;
  end
  always @(posedge ss_n[1]) t_ss_rise = $realtime;
  always @(negedge clk) if (rst_n && ((ss_n | cur_sel) != '1)) unsel_bad = 1'b1;

  task automatic chk(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // bus tasks start and end on a falling clock edge
  task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [15:0] d);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic wait_eop();
    logic [15:0] s;
    for (int i = 0; i < 400; i++) begin
      bus_rd(3'd2, s);
      if (s[9]) return;
    end
    chk(1'b0, "R9 eop timeout", s, 16'h0200);
  endtask

  task automatic xfer(input logic [7:0] tx, input logic [7:0] dev);
    bus_wr(3'd2, 16'h0);
    dev_tx = dev;
    rises = 0;
    bus_wr(3'd1, {8'h0, tx});
    wait_eop();
  endtask

  task automatic t_reset();
    logic [15:0] d;
    bus_rd(3'd3, d); chk(d == 16'h0, "R1 ctrl", d, 16'h0);
    bus_rd(3'd4, d); chk(d == 16'h0, "R1 sel", d, 16'h0);
    bus_rd(3'd2, d); chk(d == 16'h0040, "R1 status", d, 16'h0040);
    chk(ss_n == '1 && !irq && !sclk, "R1 pins", {12'h0, ss_n, irq}, 16'h000E);
  endtask

  task automatic t_regs();
    logic [15:0] d;
    bus_wr(3'd3, 16'hFFFF);
    bus_rd(3'd3, d); chk(d == 16'h07D8, "R2 ctrl mask", d, 16'h07D8);
    bus_rd(3'd3, d); chk(d == 16'h07D8, "R2 ctrl reread", d, 16'h07D8);
    bus_wr(3'd3, 16'h0);
    bus_wr(3'd4, 16'hFFFD);
    bus_rd(3'd4, d); chk(d == 16'h0005, "R2 sel", d, 16'h0005);
    bus_wr(3'd4, 16'h0);
  endtask

  task automatic t_xfer();
    logic [15:0] d;
    cur_sel = 3'b010;
    bus_wr(3'd4, 16'h0002);
    bus_wr(3'd2, 16'h0);
    dev_tx = 8'h3C; rises = 0; unsel_bad = 1'b0;
    bus_wr(3'd1, 16'h00A5);
    bus_rd(3'd2, d); chk(d[6] == 1'b0, "R6 trdy low after write", d, 16'h0);
    wait_eop();
    bus_rd(3'd2, d); chk(d == 16'h02C0, "R3 R9 status after word", d, 16'h02C0);
    chk(dev_rx == 8'hA5, "R3 mosi byte", {8'h0, dev_rx}, 16'h00A5);
    chk(rises == 8, "R3 sclk count", 16'(rises), 16'd8);
    chk((t_rise1 - t_rise0) == CLK_DIV*TCLK, "R3 sclk period", 16'(int'(t_rise1 - t_rise0)), 16'(CLK_DIV*8));
    chk((t_ss_rise - t_last_fall) == (CLK_DIV/2)*TCLK, "R4 ss tail", 16'(int'(t_ss_rise - t_last_fall)), 16'((CLK_DIV/2)*8));
    chk(ss_n == '1, "R4 ss released", {13'h0, ss_n}, 16'h0007);
    chk(!unsel_bad, "R4 unselected lines", {15'h0, unsel_bad}, 16'h0);
    bus_rd(3'd0, d); chk(d == 16'h003C, "R3 rx byte", d, 16'h003C);
    bus_rd(3'd2, d); chk(d[7] == 1'b0, "R7 rrdy cleared by read", d, 16'h0);
  endtask

  task automatic t_overrun();
    logic [15:0] d;
    xfer(8'h11, 8'h77);
    xfer(8'h22, 8'h88);
    bus_rd(3'd2, d); chk(d == 16'h02E8, "R7 R8 overrun status", d, 16'h02E8);
    bus_rd(3'd0, d); chk(d == 16'h0077, "R7 rx kept", d, 16'h0077);
    bus_wr(3'd2, 16'h1234);
    bus_rd(3'd2, d); chk(d == 16'h0040, "R8 status cleared", d, 16'h0040);
    dev_tx = 8'h00; rises = 0;
    bus_wr(3'd1, 16'h0033);
    bus_wr(3'd1, 16'h0044);
    bus_rd(3'd2, d); chk(d[4] && d[5], "R6 R8 toe and err", d, 16'h0070);
    wait_eop();
    chk(dev_rx == 8'h33 && rises == 8, "R6 second write ignored", {8'h0, dev_rx}, 16'h0033);
    bus_wr(3'd2, 16'h0);
    bus_rd(3'd2, d); chk(d[4] == 1'b0 && d[5] == 1'b0, "R8 toe cleared", d, 16'h00C0);
    bus_rd(3'd0, d);
  endtask

  task automatic t_irq();
    logic [15:0] d;
    bus_wr(3'd3, 16'h0);
    xfer(8'h5A, 8'hC3);
    #1 chk(!irq, "R10 no enables", {15'h0, irq}, 16'h0);
    bus_wr(3'd3, 16'h0080);
    #1 chk(irq, "R10 rrdy enabled", {15'h0, irq}, 16'h1);
    bus_rd(3'd0, d);
    #1 chk(!irq, "R10 rrdy cleared", {15'h0, irq}, 16'h0);
    bus_wr(3'd3, 16'h0040);
    #1 chk(irq, "R10 trdy enabled", {15'h0, irq}, 16'h1);
    bus_wr(3'd3, 16'h0200);
    #1 chk(irq, "R10 eop enabled", {15'h0, irq}, 16'h1);
    bus_wr(3'd3, 16'h0008);
    #1 chk(!irq, "R10 roe enabled flag clear", {15'h0, irq}, 16'h0);
    xfer(8'h01, 8'h02);
    xfer(8'h03, 8'h04);
    #1 chk(irq, "R10 roe enabled flag set", {15'h0, irq}, 16'h1);
    bus_wr(3'd3, 16'h0100);
    #1 chk(irq, "R10 any-error enable", {15'h0, irq}, 16'h1);
    bus_wr(3'd3, 16'h0010);
    #1 chk(!irq, "R10 toe enable only", {15'h0, irq}, 16'h0);
    bus_wr(3'd3, 16'h0);
    bus_wr(3'd2, 16'h0);
    bus_rd(3'd0, d);
  endtask

  task automatic t_hold();
    cur_sel = 3'b100;
    bus_wr(3'd4, 16'h0004);
    bus_wr(3'd3, 16'h0400);
    #1 chk(ss_n == 3'b011, "R5 hold while idle", {13'h0, ss_n}, 16'h0003);
    xfer(8'hF0, 8'h0F);
    #1 chk(ss_n == 3'b011, "R5 hold after word", {13'h0, ss_n}, 16'h0003);
    bus_wr(3'd3, 16'h0);
    #1 chk(ss_n == 3'b111, "R5 release", {13'h0, ss_n}, 16'h0007);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_xfer();
    t_overrun();
    t_irq();
    t_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(TCLK * 150000);
    checks++; errors++;
    $display("FAIL watchdog act=running exp=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule